// File: doc/BRIEF.md
# Adaptive Bit-Period Synchronizer

This block recovers bit timing on a single-wire bus that carries its own clock as mid-bit transitions. While the line idles high, a falling edge starts a command. The start header that follows is a run of alternating bits, so the line toggles once per bit period and never at bit boundaries. The block counts fast system-clock cycles across a fixed number of those intervals and divides the total by that count. The result is the bit period used for the rest of the command.

Once the period is learned, a phase counter free-runs through each bit. It predicts where the next mid-bit transition falls and looks for it in a window a quarter period wide on each side. The direction of the first transition inside the window gives the data bit. When the bit is flagged as an acknowledge slot by the mode controller, the counter is moved so that the observed edge sits exactly on the prediction. In all other bits the block keeps its current phase and does not correct it. If the window closes with no transition, or the header is unusable, the block reports a synchronization error and drops lock. It then waits for the line to return high and for the next falling edge.

Top module: `bitper_sync`

## Requirements
- R1: While reset is asserted and right after it, `lock_o`, `mid_stb_o`, `end_stb_o`, `sync_err_o` are 0 and `period_o` is 0.
- R2: With the line idle high, a falling edge followed by 2^HDR_LOG2 further edges makes `period_o` equal to the floor of the sum of those 2^HDR_LOG2 edge-to-edge intervals (in clock cycles) divided by 2^HDR_LOG2, and `lock_o` goes to 1.
- R3: A header whose averaged period is below MIN_PERIOD, or whose cycle count reaches 2^CNT_W-1 before the last header edge, produces a one-cycle `sync_err_o` pulse and leaves `lock_o` at 0.
- R4: Data bits are decoded from the first transition inside the window: rising gives `bit_o`=1, falling gives `bit_o`=0. `mid_stb_o` pulses for one cycle, one cycle after the edge is seen, once per bit.
- R5: The window spans predicted mid ± floor(period/2)/… exactly positions floor(P/2)-floor(P/4) to floor(P/2)+floor(P/4) of the phase counter, both ends included. Transitions outside it, such as bit-boundary edges, are ignored.
- R6: If no transition falls in the window, `sync_err_o` pulses one cycle after the window's last position, `lock_o` drops, and that bit produces no `mid_stb_o`.
- R7: A window transition seen while `mak_i` is 1 moves the phase so that `end_stb_o` follows `mid_stb_o` by exactly P-floor(P/2)-1 cycles, whatever the edge's offset.
- R8: A window transition seen while `mak_i` is 0 leaves the phase unchanged: an edge that is d cycles late gives a `mid_stb_o`-to-`end_stb_o` gap of P-floor(P/2)-1-d.
- R9: Between corrections, `end_stb_o` pulses once per bit, exactly P cycles apart.
- R10: After an error the block ignores the line until it is high and a new falling edge arrives. The new header re-measures the period and restarts the phase with no carried-over correction.
- R11: `period_o` changes only when a header is accepted. It holds its value through lock loss and through rejected headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Data-line level, already synchronized to clk_i |
| mak_i | input | 1 | High while the current bit is an acknowledge slot |
| period_o | output | CNT_W-HDR_LOG2 | Measured bit period in clock cycles |
| lock_o | output | 1 | Timing reference valid, command in progress |
| mid_stb_o | output | 1 | One-cycle pulse: a data bit was decoded |
| end_stb_o | output | 1 | One-cycle pulse at each predicted bit boundary |
| bit_o | output | 1 | Last decoded bit value |
| sync_err_o | output | 1 | One-cycle pulse on a missed edge or a bad header |

## Verification
The assertions hold on every cycle for the structural rules of the strobes. Strobes appear only under lock, mid, end and error strobes never coincide, an error is a single pulse that leaves lock low, lock only rises with a period of at least MIN_PERIOD, and the period stays steady while locked. Quantitative timing can only be shown by driving whole commands with known bit periods and edge offsets. This covers the averaged period value, the decoded polarity, the exact window edges, the strobe gaps that prove a correction happened at acknowledge bits and not elsewhere, and the re-measurement after an error.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_HIGH,
    ST_HUNT,
    ST_HDR,
    ST_RUN
  } bps_state_e;
endpackage

// File: rtl/bps_edge_det.sv
module bps_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o
);
  logic line_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b1;
    else         line_q <= line_i;
  end

  assign edge_o = line_i ^ line_q;
endmodule

// File: rtl/bps_period_meas.sv
module bps_period_meas #(
  parameter int CNT_W    = 14,
  parameter int HDR_LOG2 = 3,
  localparam int PER_W    = CNT_W - HDR_LOG2,
  localparam int HDR_BITS = 1 << HDR_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             edge_i,
  output logic             done_o,
  output logic             ovf_o,
  output logic [PER_W-1:0] meas_o
);
  logic [CNT_W-1:0]    tot_q;
  logic [HDR_LOG2-1:0] ecnt_q;
  logic                tot_max;

  assign tot_max = (tot_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q  <= '0;
      ecnt_q <= '0;
    end else if (start_i) begin
      tot_q  <= CNT_W'(1);
      ecnt_q <= '0;
    end else if (active_i) begin
      if (!tot_max) tot_q <= tot_q + CNT_W'(1);
      if (edge_i)   ecnt_q <= ecnt_q + HDR_LOG2'(1);
    end
  end

  // tot_q equals the elapsed cycles since the first edge in the cycle of the last edge
  assign done_o = active_i & edge_i & (ecnt_q == HDR_LOG2'(HDR_BITS - 1));
  assign ovf_o  = active_i & tot_max & ~done_o;
  assign meas_o = tot_q[CNT_W-1:HDR_LOG2];
endmodule

// File: rtl/bps_phase_track.sv
module bps_phase_track #(
  parameter int PER_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PER_W-1:0] load_period_i,
  input  logic             run_i,
  input  logic             edge_i,
  input  logic             line_i,
  input  logic             mak_i,
  input  logic [PER_W-1:0] period_i,
  output logic             mid_stb_o,
  output logic             end_stb_o,
  output logic             bit_o,
  output logic             miss_o
);
  logic [PER_W-1:0] pos_q;
  logic [PER_W-1:0] half, qtr, win_lo, win_hi, last;
  logic             seen_q, in_win, hit, at_last, at_close;
  logic             mid_q, end_q, bit_q;

  assign half     = period_i >> 1;
  assign qtr      = period_i >> 2;
  assign win_lo   = half - qtr;
  assign win_hi   = half + qtr;
  assign last     = period_i - PER_W'(1);
  assign in_win   = (pos_q >= win_lo) && (pos_q <= win_hi);
  assign at_last  = (pos_q == last);
  assign at_close = (pos_q == win_hi);
  assign hit      = run_i & edge_i & in_win & ~seen_q;
  assign miss_o   = run_i & at_close & ~seen_q & ~hit;

  // pos_q == half marks the predicted mid-bit edge, pos_q wraps at bit boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      seen_q <= 1'b1;
    end else if (load_i) begin
      pos_q  <= (load_period_i >> 1) + PER_W'(1);
      seen_q <= 1'b1;
    end else if (run_i) begin
      if (hit && mak_i) pos_q <= half + PER_W'(1);
      else if (at_last) pos_q <= '0;
      else              pos_q <= pos_q + PER_W'(1);
      if (at_last)  seen_q <= 1'b0;
      else if (hit) seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q <= 1'b0;
      end_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      mid_q <= hit;
      end_q <= run_i & at_last;
      if (hit) bit_q <= line_i;
    end
  end

  assign mid_stb_o = mid_q;
  assign end_stb_o = end_q;
  assign bit_o     = bit_q;
endmodule

// File: rtl/bitper_sync.sv
module bitper_sync
  import bps_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int HDR_LOG2   = 3,
  parameter int MIN_PERIOD = 8,
  localparam int PER_W     = CNT_W - HDR_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             mak_i,
  output logic [PER_W-1:0] period_o,
  output logic             lock_o,
  output logic             mid_stb_o,
  output logic             end_stb_o,
  output logic             bit_o,
  output logic             sync_err_o
);
  bps_state_e       state_q, state_d;
  logic             edge_w, start_w, done_w, ovf_w, short_w, load_w, miss_w, hdr_fail;
  logic [PER_W-1:0] meas_w, period_q;
  logic             err_q;

  bps_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .edge_o (edge_w)
  );

  assign start_w = (state_q == ST_HUNT) & edge_w & ~line_i;

  bps_period_meas #(
    .CNT_W    (CNT_W),
    .HDR_LOG2 (HDR_LOG2)
  ) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_w),
    .active_i (state_q == ST_HDR),
    .edge_i   (edge_w),
    .done_o   (done_w),
    .ovf_o    (ovf_w),
    .meas_o   (meas_w)
  );

  assign short_w  = meas_w < PER_W'(MIN_PERIOD);
  assign load_w   = done_w & ~short_w;
  assign hdr_fail = (done_w & short_w) | ovf_w;

  bps_phase_track #(
    .PER_W (PER_W)
  ) u_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load_w),
    .load_period_i (meas_w),
    .run_i         (state_q == ST_RUN),
    .edge_i        (edge_w),
    .line_i        (line_i),
    .mak_i         (mak_i),
    .period_i      (period_q),
    .mid_stb_o     (mid_stb_o),
    .end_stb_o     (end_stb_o),
    .bit_o         (bit_o),
    .miss_o        (miss_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_HIGH: if (line_i) state_d = ST_HUNT;
      ST_HUNT:      if (start_w) state_d = ST_HDR;
      ST_HDR: begin
        if (load_w)        state_d = ST_RUN;
        else if (hdr_fail) state_d = ST_WAIT_HIGH;
      end
      ST_RUN:       if (miss_w) state_d = ST_WAIT_HIGH;
      default:      state_d = ST_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_HIGH;
      period_q <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_w) period_q <= meas_w;
      err_q <= hdr_fail | miss_w;
    end
  end

  assign period_o   = period_q;
  assign lock_o     = (state_q == ST_RUN);
  assign sync_err_o = err_q;
endmodule

// File: rtl/bps_sync_chk.sv
module bps_sync_chk #(
  parameter int PER_W      = 11,
  parameter int MIN_PERIOD = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PER_W-1:0] period_i,
  input logic             lock_i,
  input logic             mid_i,
  input logic             end_i,
  input logic             err_i
);
  a_r4_mid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_i |-> $past(lock_i));

  a_r9_end_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> $past(lock_i));

  a_r6_err_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !lock_i);

  a_r3_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);

  a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mid_i, end_i, err_i}));

  a_r2_lock_period_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> (period_i >= PER_W'(MIN_PERIOD)));

  a_r11_period_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && $past(lock_i)) |-> $stable(period_i));
endmodule

bind bitper_sync bps_sync_chk #(
  .PER_W      (PER_W),
  .MIN_PERIOD (MIN_PERIOD)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .period_i (period_o),
  .lock_i   (lock_o),
  .mid_i    (mid_stb_o),
  .end_i    (end_stb_o),
  .err_i    (sync_err_o)
);

// File: tb/bitper_sync_tb_top.sv
`timescale 1ns/1ps
module bitper_sync_tb_top;
  localparam int PER_W = 11;
  localparam int NV = 4;
  localparam int V_PER [NV] = '{64, 40, 100, 32};
  localparam int V_JIT [NV] = '{3, 5, 0, 2};
  localparam int V_DAT [NV] = '{'hA5, 'h3C, 'hFF, 'h00};
  localparam int V_SKW [NV] = '{10, -7, 15, -5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line = 1'b1;
  logic mak = 1'b0;
  logic [PER_W-1:0] period_o;
  logic lock_o, mid_stb_o, end_stb_o, bit_o, sync_err_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nb = 0, errs = 0;
  logic got_end = 1'b1, ever_lock = 1'b0;
  logic bits [32];
  int mid_cyc [32], gap [32], end_cyc [32];

  always #4 clk = ~clk;

  bitper_sync #(.CNT_W(14), .HDR_LOG2(3), .MIN_PERIOD(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .mak_i(mak),
    .period_o(period_o), .lock_o(lock_o), .mid_stb_o(mid_stb_o),
    .end_stb_o(end_stb_o), .bit_o(bit_o), .sync_err_o(sync_err_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (mid_stb_o) begin
      if (nb < 32) begin
        bits[nb] = bit_o;
        mid_cyc[nb] = cyc;
      end
      nb++;
      got_end = 1'b0;
    end
    if (end_stb_o && nb > 0 && nb <= 32 && !got_end) begin
      gap[nb-1] = cyc - mid_cyc[nb-1];
      end_cyc[nb-1] = cyc;
      got_end = 1'b1;
    end
    if (sync_err_o) errs++;
    if (lock_o) ever_lock = 1'b1;
  endtask

  task automatic hold(input int n);
    repeat (n) step();
  endtask

  task automatic clear();
    nb = 0; errs = 0; got_end = 1'b1; ever_lock = 1'b0;
  endtask

  task automatic header(input int p, input int j);
    line = 1'b1; mak = 1'b0;
    hold(20);
    line = 1'b0;
    for (int i = 0; i < 8; i++) begin
      hold((i % 2) != 0 ? p - j : p + j);
      line = ~line;
    end
    hold(p / 2);
  endtask

  task automatic send_bit(input logic b, input logic m, input int p, input int s, input logic persist);
    line = ~b; mak = m;
    hold(p / 2 + s);
    line = b;
    hold(persist ? p / 2 : p / 2 - s);
    mak = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    hold(3);
    // R1 during reset
    chk(!lock_o && !mid_stb_o && !end_stb_o && !sync_err_o, "R1 in reset", lock_o, 0);
    rst_ni = 1'b1;
    hold(2);
    chk(period_o == 0, "R1 period", int'(period_o), 0);
    chk(!lock_o && !sync_err_o && !mid_stb_o && !end_stb_o, "R1 after reset", lock_o, 0);

    // table walk: header, data byte, two MAK bits, skewed plain bit, plain bit, then silence
    for (int v = 0; v < NV; v++) begin
      automatic int p = V_PER[v];
      automatic int s = V_SKW[v];
      automatic int d = V_DAT[v];
      automatic int dec = 0;
      clear();
      header(p, V_JIT[v]);
      chk(lock_o == 1'b1, "R2 lock", lock_o, 1);
      chk(int'(period_o) == p, v == 0 ? "R2 period" : "R10 re-measured period", int'(period_o), p);
      for (int k = 7; k >= 0; k--) send_bit(d[k], 1'b0, p, 0, 1'b0);
      send_bit(1'b1, 1'b1, p, s, 1'b1);
      send_bit(1'b1, 1'b1, p, s, 1'b1);
      send_bit(1'b0, 1'b0, p, s, 1'b0);
      send_bit(1'b1, 1'b0, p, 0, 1'b0);
      hold(2 * p);
      chk(nb == 12, "R4 bit count", nb, 12);
      for (int k = 0; k < 8; k++) dec = (dec << 1) | int'(bits[k]);
      chk(dec == d, "R4 decoded byte", dec, d);
      chk(bits[8] && bits[9] && !bits[10] && bits[11], "R4 tail bits", int'(bits[10]), 0);
      chk(gap[8] == p / 2 - 1, "R7 MAK gap 1", gap[8], p / 2 - 1);
      chk(gap[9] == p / 2 - 1, "R7 MAK gap 2", gap[9], p / 2 - 1);
      chk(gap[10] == p / 2 - 1 - s, "R8 plain skewed gap", gap[10], p / 2 - 1 - s);
      chk(gap[11] == p / 2 - 1, "R8 phase kept", gap[11], p / 2 - 1);
      chk(end_cyc[2] - end_cyc[1] == p, "R9 boundary spacing", end_cyc[2] - end_cyc[1], p);
      chk(errs == 1, "R6 end-of-command miss", errs, 1);
      chk(lock_o == 1'b0, "R6 lock dropped", lock_o, 0);
      chk(int'(period_o) == p, "R11 period held", int'(period_o), p);
    end

    // R5 window edges, late and early, P=64 (quarter 16)
    clear();
    header(64, 0);
    send_bit(1'b1, 1'b0, 64, 16, 1'b0);
    send_bit(1'b0, 1'b0, 64, -16, 1'b0);
    send_bit(1'b1, 1'b0, 64, 17, 1'b0);
    hold(64);
    chk(nb == 2, "R5 edges at window limits", nb, 2);
    chk(bits[0] == 1'b1 && bits[1] == 1'b0, "R5 polarity at limits", int'(bits[1]), 0);
    chk(gap[0] == 15, "R8 late edge gap", gap[0], 15);
    chk(errs == 1, "R6 late beyond window", errs, 1);

    clear();
    header(64, 0);
    send_bit(1'b0, 1'b0, 64, -17, 1'b0);
    hold(64);
    chk(nb == 0, "R6 no strobe on early miss", nb, 0);
    chk(errs == 1, "R5 early edge ignored", errs, 1);

    // R3 short header, period must stay at the last accepted value
    clear();
    header(6, 0);
    hold(20);
    chk(errs == 1, "R3 short header error", errs, 1);
    chk(ever_lock == 1'b0, "R3 no lock", ever_lock, 0);
    chk(int'(period_o) == 64, "R11 period kept on reject", int'(period_o), 64);

    // R3 counter overflow
    clear();
    line = 1'b1; hold(20);
    line = 1'b0; hold(16500);
    chk(errs == 1, "R3 overflow error", errs, 1);
    chk(ever_lock == 1'b0, "R3 overflow no lock", ever_lock, 0);

    // R10 recovery after errors
    clear();
    header(48, 2);
    chk(lock_o == 1'b1 && int'(period_o) == 48, "R10 recovery period", int'(period_o), 48);
    send_bit(1'b0, 1'b0, 48, 0, 1'b0);
    hold(8);
    chk(nb == 1 && bits[0] == 1'b0, "R10 fresh phase decode", nb, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule